// File: doc/BRIEF.md
# Save-File Transfer Sender

This block runs the initiating side of a file-copy dialogue between two handheld units joined by a byte link. After a start pulse, it opens a session and announces the file's type and its size in 512-byte blocks. It then passes a twelve-character name and streams the file body as 128-byte chunks. After each step it waits for one specific reply byte from the partner. After every chunk it runs a commit exchange, so the partner writes the chunk to its storage before the next one is sent.

The serial port below the block carries `tx_byte` with a valid/ready handshake and hands up partner bytes on `rx_valid`. It also reports echo mismatches on `echo_err`. File bytes come from an outside source that holds `data_in` steady until `data_ready` takes it. The block ends in one of three terminal states: done, abort (the partner already holds the file) or error. That state holds until reset.

Top module: `save_xfer_sender`

## Requirements
- R1: After reset, `tx_valid`, `data_ready`, `done`, `abort` and `error` are all low, and the block waits for `start`.
- R2: A `start` pulse while idle makes the next byte offered 0x11, and 0xE0 is awaited. The block then sends 0x02, `file_type`, `block_count` and 0xFF in that order, and awaits 0x0C.
- R3: After 0x0C the block sends 0x1B and awaits 0xE0. It then sends 0x06, the twelve name characters and 0xFF. The first character is `file_name[95:88]` and the last is `file_name[7:0]`.
- R4: The reply after the name decides the branch. 0x0E continues the transfer. 0x0A raises `abort`, after which no byte is offered.
- R5: Each chunk is sent as 0x04, then 128 bytes taken from `data_in`, then 0x00, and 0xC0 is awaited. `data_ready` is high exactly when a file byte is accepted by the link.
- R6: After 0xC0 the block sends 0x10 and awaits 0xE0. It then sends 0x08, 0x00 and 0xFF, and awaits 0x0C as the commit confirmation.
- R7: The chunk count is `block_count` times 4. Between chunks the block sends 0x50 and awaits 0xE0. `done` rises on the cycle after the last commit's 0x0C is received. When `block_count` is 0, `done` rises right after the 0x0E reply.
- R8: A reply byte other than the awaited one raises `error`. The single exception is 0x0A after the name. `done`, `abort` and `error` are mutually exclusive and hold until reset.
- R9: While awaiting a reply, the block raises `error` if no `rx_valid` arrives within `timeout_limit` cycles of entering the wait. Cycles are counted from 0, so a reply on cycle `timeout_limit`-1 is still accepted.
- R10: `echo_err` while a transfer runs raises `error` on the next cycle.
- R11: While `tx_ready` is low, `tx_valid` and `tx_byte` hold. Bytes received while the block is sending are ignored.
- R12: `start` is ignored while a transfer runs or a terminal state is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a transfer (taken only while idle) |
| file_type | input | 8 | File type byte (0x33 saved data, 0xCC program) |
| block_count | input | 8 | File size in 512-byte blocks |
| file_name | input | 96 | Twelve name characters, first in the top byte |
| timeout_limit | input | 16 | Reply wait limit in cycles (at least 1) |
| data_in | input | 8 | Current file byte from the data source |
| data_ready | output | 1 | File byte taken this cycle |
| tx_byte | output | 8 | Byte offered to the link |
| tx_valid | output | 1 | `tx_byte` is valid |
| tx_ready | input | 1 | Link accepts the offered byte |
| rx_byte | input | 8 | Byte received from the partner |
| rx_valid | input | 1 | `rx_byte` is valid |
| echo_err | input | 1 | Link reports an echo mismatch |
| done | output | 1 | Transfer completed |
| abort | output | 1 | Partner already holds the file |
| error | output | 1 | Protocol, timeout or link failure |

## Verification
A partner reply and the expiry of the reply window can fall in the same cycle. The bench provokes this by holding back the reply to the opening 0x11 until the last cycle the window allows, counted from the first cycle with `tx_valid` low. It then judges that the reply is taken, `error` stays low and the next request byte follows. A later wait is then left unanswered, and the bench checks that `error` is still low on the last allowed cycle and high on the one after.

// File: rtl/save_xfer_sender.sv
module save_xfer_sender #(
  parameter int TW         = 16,
  parameter int NAME_LEN   = 12,
  parameter int CHUNK_LEN  = 128,
  parameter int BLK_CHUNKS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [7:0]            file_type,
  input  logic [7:0]            block_count,
  input  logic [8*NAME_LEN-1:0] file_name,
  input  logic [TW-1:0]         timeout_limit,
  input  logic [7:0]            data_in,
  output logic                  data_ready,
  output logic [7:0]            tx_byte,
  output logic                  tx_valid,
  input  logic                  tx_ready,
  input  logic [7:0]            rx_byte,
  input  logic                  rx_valid,
  input  logic                  echo_err,
  output logic                  done,
  output logic                  abort,
  output logic                  error
);
  localparam int NB = 8 * NAME_LEN;
  localparam int IW = $clog2(CHUNK_LEN > NAME_LEN ? CHUNK_LEN : NAME_LEN);
  localparam int CW = 9 + $clog2(BLK_CHUNKS);

  localparam logic [4:0] S_HELLO = 5'd0,  W_HELLO = 5'd1,  S_REQ   = 5'd2,  S_TYPE  = 5'd3,
                         S_SIZE  = 5'd4,  S_REQT  = 5'd5,  W_GO    = 5'd6,  S_GO    = 5'd7,
                         W_GO2   = 5'd8,  S_NAMEH = 5'd9,  S_NAME  = 5'd10, S_NAMET = 5'd11,
                         W_NAME  = 5'd12, S_CHKH  = 5'd13, S_DATA  = 5'd14, S_CHKT  = 5'd15,
                         W_CHK   = 5'd16, S_PRE   = 5'd17, W_PRE   = 5'd18, S_CMT   = 5'd19,
                         S_CMT1  = 5'd20, S_CMT2  = 5'd21, W_CMT   = 5'd22, S_NEXT  = 5'd23,
                         W_NEXT  = 5'd24;

  typedef enum logic [2:0] {P_IDLE, P_RUN, P_DONE, P_ABORT, P_ERR} phase_t;

  phase_t          phase;
  logic [4:0]      step;
  logic [IW-1:0]   idx;
  logic [CW-1:0]   chunk;
  logic [TW-1:0]   tmr;
  logic [7:0]      type_q, count_q;
  logic [NB-1:0]   name_q;
  logic            waiting, running, fire;
  logic [7:0]      want;
  logic [CW-1:0]   total;

  assign running    = (phase == P_RUN);
  assign tx_valid   = running && !waiting;
  assign fire       = tx_valid && tx_ready;
  assign data_ready = fire && (step == S_DATA);
  assign total      = CW'(count_q) * CW'(BLK_CHUNKS);
  assign done       = (phase == P_DONE);
  assign abort      = (phase == P_ABORT);
  assign error      = (phase == P_ERR);

  always_comb begin
    waiting = 1'b0;
    tx_byte = 8'h00;
    want    = 8'h00;
    case (step)
      S_HELLO: tx_byte = 8'h11;
      S_REQ:   tx_byte = 8'h02;
      S_TYPE:  tx_byte = type_q;
      S_SIZE:  tx_byte = count_q;
      S_REQT, S_NAMET, S_CMT2: tx_byte = 8'hFF;
      S_GO:    tx_byte = 8'h1B;
      S_NAMEH: tx_byte = 8'h06;
      S_NAME:  tx_byte = name_q[NB-1 -: 8];
      S_CHKH:  tx_byte = 8'h04;
      S_DATA:  tx_byte = data_in;
      S_CHKT, S_CMT1: tx_byte = 8'h00;
      S_PRE:   tx_byte = 8'h10;
      S_CMT:   tx_byte = 8'h08;
      S_NEXT:  tx_byte = 8'h50;
      W_HELLO, W_GO2, W_PRE, W_NEXT: begin waiting = 1'b1; want = 8'hE0; end
      W_GO, W_CMT:                   begin waiting = 1'b1; want = 8'h0C; end
      W_NAME:                        begin waiting = 1'b1; want = 8'h0E; end
      W_CHK:                         begin waiting = 1'b1; want = 8'hC0; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= P_IDLE;
      step    <= S_HELLO;
      idx     <= '0;
      chunk   <= '0;
      tmr     <= '0;
      type_q  <= '0;
      count_q <= '0;
      name_q  <= '0;
    end else if (phase == P_IDLE) begin
      if (start) begin
        phase   <= P_RUN;
        step    <= S_HELLO;
        idx     <= '0;
        chunk   <= '0;
        tmr     <= '0;
        type_q  <= file_type;
        count_q <= block_count;
        name_q  <= file_name;
      end
    end else if (running) begin
      if (echo_err) begin
        phase <= P_ERR;
      end else if (waiting) begin
        if (rx_valid) begin
          tmr <= '0;
          if (rx_byte != want) begin
            phase <= (step == W_NAME && rx_byte == 8'h0A) ? P_ABORT : P_ERR;
          end else if (step == W_NAME && total == '0) begin
            phase <= P_DONE;
          end else if (step == W_CMT) begin
            if (chunk == total - 1'b1) phase <= P_DONE;
            else begin
              chunk <= chunk + 1'b1;
              step  <= S_NEXT;
            end
          end else if (step == W_NEXT) begin
            step <= S_CHKH;
          end else begin
            step <= step + 1'b1;
          end
        end else if (tmr == timeout_limit - 1'b1) begin
          phase <= P_ERR;
        end else begin
          tmr <= tmr + 1'b1;
        end
      end else if (fire) begin
        if (step == S_NAME) begin
          name_q <= name_q << 8;
          idx    <= (idx == IW'(NAME_LEN - 1)) ? '0 : idx + 1'b1;
          if (idx == IW'(NAME_LEN - 1)) step <= step + 1'b1;
        end else if (step == S_DATA) begin
          idx <= (idx == IW'(CHUNK_LEN - 1)) ? '0 : idx + 1'b1;
          if (idx == IW'(CHUNK_LEN - 1)) step <= step + 1'b1;
        end else begin
          step <= step + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/save_xfer_sender_chk.sv
module save_xfer_sender_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       running,
  input logic [7:0] tx_byte,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       data_ready,
  input logic       echo_err,
  input logic       done,
  input logic       abort,
  input logic       error
);
  assert_open_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !running && !done && !abort && !error |=> tx_valid && tx_byte == 8'h11);

  assert_quiet_after_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done || abort || error) |-> !tx_valid && !data_ready);

  assert_take_on_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |-> tx_valid && tx_ready);

  assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, abort, error}));

  assert_error_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> error);

  assert_done_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  assert_abort_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> abort);

  assert_echo_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
    running && echo_err |=> error);

  assert_hold_offer_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !echo_err |=> tx_valid);
endmodule

bind save_xfer_sender save_xfer_sender_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .running(running),
  .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .data_ready(data_ready), .echo_err(echo_err),
  .done(done), .abort(abort), .error(error)
);

// File: tb/save_xfer_sender_bench.sv
module save_xfer_sender_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, start, tx_ready, rx_valid, echo_err;
  logic [7:0]  file_type, block_count, rx_byte, data_in;
  logic [95:0] file_name;
  logic [15:0] timeout_limit;
  logic        data_ready, tx_valid, done, abort, error;
  logic [7:0]  tx_byte;

  int n_checks = 0, n_fails = 0, dcount = 0, ecount = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  save_xfer_sender u_save_xfer_sender (
    .clk(clk), .rst_n(rst_n), .start(start), .file_type(file_type),
    .block_count(block_count), .file_name(file_name), .timeout_limit(timeout_limit),
    .data_in(data_in), .data_ready(data_ready), .tx_byte(tx_byte), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_byte(rx_byte), .rx_valid(rx_valid), .echo_err(echo_err),
    .done(done), .abort(abort), .error(error));

  always @(posedge clk) if (data_ready) dcount <= dcount + 1;
  assign data_in = 8'(dcount * 3 + 33);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; start = 0; tx_ready = 1; rx_valid = 0; echo_err = 0; rx_byte = 0;
    file_type = 8'h33; block_count = 8'd1; file_name = "SLOT_ALPHA01"; timeout_limit = 16'd40;
    repeat (3) @(negedge clk);
    dcount = 0; ecount = 0;
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1; @(negedge clk); start = 0;
  endtask

  task automatic expect_tx(input logic [7:0] b, input string tag, input bit is_data = 0);
    int guard = 0;
    while (!tx_valid && guard < 100) begin @(negedge clk); guard++; end
    chk(tx_valid && tx_byte == b, tag, tx_byte, b);
    chk(data_ready == is_data, "R5 data_ready", data_ready, is_data);
    @(negedge clk);
  endtask

  task automatic reply(input logic [7:0] b, input int dly = 0, input bit also_start = 0);
    repeat (dly) @(negedge clk);
    rx_byte = b; rx_valid = 1; start = also_start;
    @(negedge clk);
    rx_valid = 0; start = 0;
  endtask

  task automatic header(input logic [7:0] cnt);
    block_count = cnt;
    pulse_start();
    expect_tx(8'h11, "R2 hello");
    reply(8'hE0);
    expect_tx(8'h02, "R2 request");
    expect_tx(file_type, "R2 type");
    expect_tx(cnt, "R2 size");
    expect_tx(8'hFF, "R2 terminator");
    reply(8'h0C);
    expect_tx(8'h1B, "R3 proceed");
    reply(8'hE0);
    expect_tx(8'h06, "R3 name head");
    for (int i = 0; i < 12; i++) expect_tx(file_name[95-8*i -: 8], "R3 name char");
    expect_tx(8'hFF, "R3 name end");
  endtask

  task automatic chunk(input bit last);
    expect_tx(8'h04, "R5 chunk head");
    for (int i = 0; i < 128; i++) begin
      expect_tx(8'(ecount * 3 + 33), "R5 data byte", 1);
      ecount++;
    end
    expect_tx(8'h00, "R5 chunk end");
    reply(8'hC0);
    expect_tx(8'h10, "R6 pre-commit");
    reply(8'hE0);
    expect_tx(8'h08, "R6 commit");
    expect_tx(8'h00, "R6 commit arg");
    expect_tx(8'hFF, "R6 commit end");
    reply(8'h0C);
    if (!last) begin
      expect_tx(8'h50, "R7 next");
      reply(8'hE0);
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk(!tx_valid && !data_ready, "R1 idle link", tx_valid, 0);
    chk(!done && !abort && !error, "R1 status", {done, abort, error}, 0);
  endtask

  task automatic t_full();
    do_reset();
    header(8'd1);
    reply(8'h0E, 2, 1);
    for (int c = 0; c < 4; c++) begin
      chk(!done, "R7 done early", done, 0);
      chunk(c == 3);
    end
    chk(done && !error && !abort, "R7 done", {done, abort, error}, 4);
    chk(ecount == 512, "R7 byte total", ecount, 512);
    chk(!tx_valid, "R4 quiet after done", tx_valid, 0);
  endtask

  task automatic t_exists();
    do_reset();
    header(8'd2);
    reply(8'h0A);
    chk(abort && !error, "R4 abort", {done, abort, error}, 2);
    for (int i = 0; i < 5; i++) begin
      chk(!tx_valid, "R4 no byte after abort", tx_valid, 0);
      @(negedge clk);
    end
  endtask

  task automatic t_zero();
    do_reset();
    header(8'd0);
    reply(8'h0E);
    chk(done && !tx_valid, "R7 zero blocks", {done, tx_valid}, 2);
  endtask

  task automatic t_bad_reply();
    do_reset();
    pulse_start();
    expect_tx(8'h11, "R2 hello");
    reply(8'h55);
    chk(error, "R8 wrong reply", error, 1);
    pulse_start();
    repeat (3) @(negedge clk);
    chk(error && !tx_valid, "R12 start ignored", {error, tx_valid}, 2);
  endtask

  task automatic t_timeout();
    do_reset();
    timeout_limit = 16'd10;
    pulse_start();
    expect_tx(8'h11, "R2 hello");
    reply(8'hE0, 9);
    chk(!error, "R9 last-cycle reply taken", error, 0);
    expect_tx(8'h02, "R9 continues");
    expect_tx(file_type, "R2 type");
    expect_tx(8'd1, "R2 size");
    expect_tx(8'hFF, "R2 terminator");
    repeat (9) @(negedge clk);
    chk(!error, "R9 within window", error, 0);
    @(negedge clk);
    chk(error, "R9 window expired", error, 1);
  endtask

  task automatic t_echo();
    do_reset();
    header(8'd1);
    reply(8'h0E);
    expect_tx(8'h04, "R5 chunk head");
    expect_tx(8'(ecount * 3 + 33), "R5 data byte", 1);
    echo_err = 1; @(negedge clk); echo_err = 0;
    chk(error && !tx_valid, "R10 echo fault", {error, tx_valid}, 2);
  endtask

  task automatic t_stall();
    do_reset();
    tx_ready = 0;
    pulse_start();
    for (int i = 0; i < 3; i++) begin
      chk(tx_valid && tx_byte == 8'h11, "R11 held offer", tx_byte, 8'h11);
      rx_byte = 8'h0A; rx_valid = 1;
      @(negedge clk);
      rx_valid = 0;
    end
    chk(!error && !abort, "R11 rx while sending ignored", {abort, error}, 0);
    tx_ready = 1;
    expect_tx(8'h11, "R11 hello after stall");
    reply(8'hE0);
    expect_tx(8'h02, "R11 continues");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_full();
    t_exists();
    t_zero();
    t_bad_reply();
    t_timeout();
    t_echo();
    t_stall();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule